// File: doc/BRIEF.md
# I2C SCL Clock Divider and Phase Timer

This block turns a fast peripheral clock into the bit timing of an I2C controller. A prescaler divides the peripheral clock by one more than a programmed divide value and produces a one-cycle reference tick. A phase counter then times the SCL waveform in units of that tick. One full SCL period lasts a base of 20 ticks, plus eight ticks for each step of a 6-bit gap field, plus a compensation count. The compensation count covers the rise time, the fall time and the internal delay, and firmware rounds it up to whole ticks.

While the controller holds `run` high, the block first keeps SCL released for a programmable setup interval. This is the first-bit spacing between the data line and the clock. It then alternates low and high phases. The low phase gets the extra tick when the period is odd. The setup interval is loaded through a small write port. Its code maps to (code + 2) ticks, and reset leaves the code at 4, which gives 6 ticks.

Three strobes tell the controller where it stands in the bit. `setup_stb` marks the start of the sequence. `change_stb` marks the point where SCL is about to fall and the data line may change. `sample_stb` marks the first tick of a high phase on which SCL is really seen high. If another device holds SCL low during a high phase, the count waits until the line is released.

Top module: `i2c_sclk_timer`

## Requirements
- R1: While `run` is high, `tick` is high for one clock in every (pre_div + 1) clocks. The first tick comes pre_div clocks after the first clock edge with `run` high. `tick` is low whenever `run` is low.
- R2: With P = 20 + 8*gap_steps + edge_comp, each low phase of `scl_en` lasts ceil(P/2) ticks and each unstretched high phase lasts floor(P/2) ticks. Each tick is (pre_div + 1) clocks.
- R3: The setup interval lasts (code + 2) ticks, where code is the 4-bit value last written through `lead_wr`/`lead_din`. Code 4 gives 6 ticks and code 15 gives 17 ticks. After reset the code is 4. During the setup interval `scl_en` stays 1.
- R4: `setup_stb` is high for exactly the one clock in which `run` is first seen high while the block is idle.
- R5: `change_stb` pulses once at the end of the setup interval and once at the end of every high phase. It is high in the clock just before `scl_en` falls to 0.
- R6: `sample_stb` pulses exactly once per high phase. It pulses on the first tick on which `scl_in` is high, and only while `scl_en` is 1.
- R7: While `scl_in` is low during a high phase, ticks do not advance the high-phase count. A high phase that is stretched over m ticks lasts floor(P/2) + m ticks.
- R8: One clock after `run` goes low, `scl_en` is 1 and all strobes are 0. The next assertion of `run` starts again from the setup interval.
- R9: During reset and right after it, `scl_en` is 1 and `tick`, `setup_stb`, `change_stb` and `sample_stb` are 0.
- R10: The prescaled tick rate, PCLK_KHZ / (pre_div + 1), stays below 20000 kHz whenever `run` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Controller request to time SCL |
| pre_div | input | PRE_W (3) | Prescale value; the tick is clk/(pre_div+1) |
| gap_steps | input | DIV_W (6) | Period extension in steps of 8 ticks |
| edge_comp | input | COMP_W (6) | Rise/fall/delay compensation in ticks |
| lead_wr | input | 1 | Write strobe for the setup code |
| lead_din | input | LEAD_W (4) | Setup code; the interval is code+2 ticks |
| scl_in | input | 1 | Sensed SCL line level |
| tick | output | 1 | Prescaled reference tick |
| scl_en | output | 1 | 1 = release SCL high, 0 = drive SCL low |
| setup_stb | output | 1 | Start of the setup interval |
| change_stb | output | 1 | Data change point; SCL falls next clock |
| sample_stb | output | 1 | Data sample point in the high phase |

## Verification
The assertions assume that `pre_div`, `gap_steps` and `edge_comp` stay constant while `run` is high. They also assume that `pre_div` keeps the tick below the rate limit, and that `scl_in` is low only when the block drives SCL low or when a device stretches a high phase. The bench changes fields only while `run` is low and draws pre_div from 2 to 4 at the 50 MHz clock. It models stretching as a wired-AND of `scl_en` with a hold signal that lasts a whole number of tick intervals. This makes the number of lost ticks exact.

// File: rtl/sclk_pkg.sv
`timescale 1ns/1ps
package sclk_pkg;
  // Phase of the SCL timer
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_LOW   = 2'd2,
    ST_HIGH  = 2'd3
  } sclk_state_e;

  // Fixed part of every SCL period, in ticks
  localparam int unsigned BASE_TICKS = 20;
  // Ticks added per gap step
  localparam int unsigned GAP_STEP   = 8;
  // Offset between the setup code and the setup length in ticks
  localparam int unsigned LEAD_OFS   = 2;
endpackage

// File: rtl/sclk_prescale.sv
`timescale 1ns/1ps
module sclk_prescale #(
  parameter int unsigned PRE_W       = 3,
  parameter int unsigned PCLK_KHZ    = 50000,
  parameter int unsigned ICK_MAX_KHZ = 20000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre_div,
  output logic             tick
);
  logic [PRE_W-1:0] pcnt_q, pcnt_d;
  logic             pcnt_en;

  always_comb begin
    tick    = run && (pcnt_q == pre_div);
    pcnt_en = run || (pcnt_q != '0);
    if (!run || tick) pcnt_d = '0;
    else              pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (pcnt_en) pcnt_q <= pcnt_d;
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pre_div != '0) |=> !tick);

  // R10
  ick_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ((PCLK_KHZ / (32'(pre_div) + 32'd1)) < ICK_MAX_KHZ));
endmodule

// File: rtl/sclk_phase_len.sv
`timescale 1ns/1ps
module sclk_phase_len
  import sclk_pkg::*;
#(
  parameter int unsigned DIV_W  = 6,
  parameter int unsigned COMP_W = 6,
  parameter int unsigned PER_W  = 10
) (
  input  logic [DIV_W-1:0]  gap_steps,
  input  logic [COMP_W-1:0] edge_comp,
  output logic [PER_W-1:0]  low_len,
  output logic [PER_W-1:0]  high_len
);
  logic [PER_W-1:0] period;

  always_comb begin
    period   = PER_W'(BASE_TICKS)
             + (PER_W'(gap_steps) << $clog2(GAP_STEP))
             + PER_W'(edge_comp);
    low_len  = (period + PER_W'(1)) >> 1;
    high_len = period >> 1;
  end
endmodule

// File: rtl/sclk_lead_reg.sv
`timescale 1ns/1ps
module sclk_lead_reg
  import sclk_pkg::*;
#(
  parameter int unsigned LEAD_W   = 4,
  parameter int unsigned LEAD_RST = 4,
  localparam int unsigned LT_W    = LEAD_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [LEAD_W-1:0] din,
  output logic [LT_W-1:0]   lead_ticks
);
  logic [LEAD_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  code_q <= LEAD_W'(LEAD_RST);
    else if (wr) code_q <= din;
  end

  assign lead_ticks = LT_W'(code_q) + LT_W'(LEAD_OFS);

  // R3
  lead_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (lead_ticks == LT_W'($past(din)) + LT_W'(LEAD_OFS)));
endmodule

// File: rtl/sclk_phase_fsm.sv
`timescale 1ns/1ps
module sclk_phase_fsm
  import sclk_pkg::*;
#(
  parameter int unsigned PER_W = 10,
  parameter int unsigned LT_W  = 5,
  localparam int unsigned CNT_W = (PER_W > LT_W) ? PER_W : LT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             scl_in,
  input  logic [PER_W-1:0] low_len,
  input  logic [PER_W-1:0] high_len,
  input  logic [LT_W-1:0]  lead_ticks,
  output logic             scl_en,
  output logic             setup_stb,
  output logic             change_stb,
  output logic             sample_stb
);
  sclk_state_e      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             smp_q, smp_d;
  logic             step_en;

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    smp_d      = smp_q;
    setup_stb  = 1'b0;
    change_stb = 1'b0;
    sample_stb = 1'b0;
    if (!run) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
      smp_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          setup_stb = 1'b1;
          st_d      = ST_SETUP;
          cnt_d     = CNT_W'(lead_ticks) - 1'b1;
        end
        ST_SETUP: begin
          if (tick) begin
            if (cnt_q == '0) begin
              change_stb = 1'b1;
              st_d       = ST_LOW;
              cnt_d      = CNT_W'(low_len) - 1'b1;
            end else begin
              cnt_d = cnt_q - 1'b1;
            end
          end
        end
        ST_LOW: begin
          if (tick) begin
            if (cnt_q == '0) begin
              st_d  = ST_HIGH;
              cnt_d = CNT_W'(high_len) - 1'b1;
              smp_d = 1'b0;
            end else begin
              cnt_d = cnt_q - 1'b1;
            end
          end
        end
        ST_HIGH: begin
          if (tick && scl_in) begin
            sample_stb = !smp_q;
            smp_d      = 1'b1;
            if (cnt_q == '0) begin
              change_stb = 1'b1;
              st_d       = ST_LOW;
              cnt_d      = CNT_W'(low_len) - 1'b1;
            end else begin
              cnt_d = cnt_q - 1'b1;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  assign step_en = run || (st_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      smp_q <= 1'b0;
    end else if (step_en) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      smp_q <= smp_d;
    end
  end

  assign scl_en = (st_q != ST_LOW);

  // R2
  half_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (low_len >= high_len) && ((low_len - high_len) <= PER_W'(1)));

  // R4
  setup_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_stb |=> !setup_stb);

  // R5
  change_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    change_stb |=> !scl_en);

  // R6
  sample_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (scl_in && scl_en));

  // R7
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && st_q == ST_HIGH && !scl_in) |=> (st_q == ST_HIGH) && $stable(cnt_q));

  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> scl_en);
endmodule

// File: rtl/i2c_sclk_timer.sv
`timescale 1ns/1ps
module i2c_sclk_timer #(
  parameter int unsigned PRE_W       = 3,
  parameter int unsigned DIV_W       = 6,
  parameter int unsigned COMP_W      = 6,
  parameter int unsigned LEAD_W      = 4,
  parameter int unsigned LEAD_RST    = 4,
  parameter int unsigned PCLK_KHZ    = 50000,
  parameter int unsigned ICK_MAX_KHZ = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [PRE_W-1:0]  pre_div,
  input  logic [DIV_W-1:0]  gap_steps,
  input  logic [COMP_W-1:0] edge_comp,
  input  logic              lead_wr,
  input  logic [LEAD_W-1:0] lead_din,
  input  logic              scl_in,
  output logic              tick,
  output logic              scl_en,
  output logic              setup_stb,
  output logic              change_stb,
  output logic              sample_stb
);
  localparam int unsigned PER_MAX = sclk_pkg::BASE_TICKS
                                  + sclk_pkg::GAP_STEP * ((2 ** DIV_W) - 1)
                                  + ((2 ** COMP_W) - 1);
  localparam int unsigned PER_W   = $clog2(PER_MAX + 1);
  localparam int unsigned LT_W    = LEAD_W + 1;

  logic [1:0]       rst_sync_q;
  logic             rst_n_i;
  logic [PER_W-1:0] low_len, high_len;
  logic [LT_W-1:0]  lead_ticks;

  // Reset asserts asynchronously and releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  sclk_prescale #(
    .PRE_W(PRE_W), .PCLK_KHZ(PCLK_KHZ), .ICK_MAX_KHZ(ICK_MAX_KHZ)
  ) u_pre (
    .clk(clk), .rst_n(rst_n_i), .run(run), .pre_div(pre_div), .tick(tick)
  );

  sclk_phase_len #(
    .DIV_W(DIV_W), .COMP_W(COMP_W), .PER_W(PER_W)
  ) u_len (
    .gap_steps(gap_steps), .edge_comp(edge_comp),
    .low_len(low_len), .high_len(high_len)
  );

  sclk_lead_reg #(
    .LEAD_W(LEAD_W), .LEAD_RST(LEAD_RST)
  ) u_lead (
    .clk(clk), .rst_n(rst_n_i), .wr(lead_wr), .din(lead_din),
    .lead_ticks(lead_ticks)
  );

  sclk_phase_fsm #(
    .PER_W(PER_W), .LT_W(LT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n_i), .run(run), .tick(tick), .scl_in(scl_in),
    .low_len(low_len), .high_len(high_len), .lead_ticks(lead_ticks),
    .scl_en(scl_en), .setup_stb(setup_stb), .change_stb(change_stb),
    .sample_stb(sample_stb)
  );

  // R9
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(run) |-> scl_en);
endmodule

// File: tb/i2c_sclk_timer_tb_top.sv
`timescale 1ns/1ps
module i2c_sclk_timer_tb_top;
  logic       clk;
  logic       rst_n;
  logic       run;
  logic [2:0] pre_div;
  logic [5:0] gap_steps;
  logic [5:0] edge_comp;
  logic       lead_wr;
  logic [3:0] lead_din;
  logic       stretch;
  logic       scl_in;
  logic       tick, scl_en, setup_stb, change_stb, sample_stb;

  int errs;
  int checks;

  assign scl_in = scl_en && !stretch;

  i2c_sclk_timer dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .pre_div(pre_div),
    .gap_steps(gap_steps), .edge_comp(edge_comp), .lead_wr(lead_wr),
    .lead_din(lead_din), .scl_in(scl_in), .tick(tick), .scl_en(scl_en),
    .setup_stb(setup_stb), .change_stb(change_stb), .sample_stb(sample_stb)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int f_period(int g, int r);
    return 20 + 8 * g + r;
  endfunction
  function automatic int f_low(int g, int r);
    return (f_period(g, r) + 1) / 2;
  endfunction
  function automatic int f_high(int g, int r);
    return f_period(g, r) / 2;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic write_lead(input int code);
    @(negedge clk);
    lead_wr  = 1'b1;
    lead_din = 4'(code);
    @(negedge clk);
    lead_wr  = 1'b0;
  endtask

  task automatic run_case(input int cdf, input int g, input int r,
                          input int lead, input int m, input int nbits);
    int n, tk, chg, nl, nh, smp, sc, hexp;
    @(negedge clk);
    pre_div   = 3'(cdf);
    gap_steps = 6'(g);
    edge_comp = 6'(r);
    run       = 1'b1;
    #1;
    chk(setup_stb == 1'b1, "R4 setup strobe", int'(setup_stb), 1);
    n = 0; tk = 0; chg = 0;
    while (1) begin
      @(posedge clk); @(negedge clk);
      n++;
      if (tick) tk++;
      if (!scl_en || n > 20000) break;
      if (change_stb) chg++;
    end
    chk(n == lead * (cdf + 1), "R3 setup length", n, lead * (cdf + 1));
    chk(tk == lead, "R1 tick count", tk, lead);
    chk(chg == 1, "R5 change at setup end", chg, 1);
    for (int b = 0; b < nbits; b++) begin
      nl = 1;
      while (1) begin
        @(posedge clk); @(negedge clk);
        if (scl_en || nl > 20000) break;
        nl++;
      end
      chk(nl == f_low(g, r) * (cdf + 1), "R2 low length", nl, f_low(g, r) * (cdf + 1));
      sc = (b == 0) ? m * (cdf + 1) : 0;
      stretch = (sc > 0);
      nh = 1; smp = sample_stb ? 1 : 0; chg = change_stb ? 1 : 0;
      while (1) begin
        @(posedge clk); @(negedge clk);
        if (sc > 0) begin
          sc--;
          if (sc == 0) stretch = 1'b0;
        end
        #1;
        if (!scl_en || nh > 20000) break;
        nh++;
        if (sample_stb) smp++;
        if (change_stb) chg++;
      end
      hexp = (f_high(g, r) + ((b == 0) ? m : 0)) * (cdf + 1);
      if (b == 0 && m > 0)
        chk(nh == hexp, "R7 stretched high length", nh, hexp);
      else
        chk(nh == hexp, "R2 high length", nh, hexp);
      chk(smp == 1, "R6 one sample per high", smp, 1);
      chk(chg == 1, "R5 one change per high", chg, 1);
    end
    @(negedge clk);
    run = 1'b0;
    #1;
    chk(tick == 1'b0, "R1 no tick when stopped", int'(tick), 0);
    @(posedge clk); @(negedge clk);
    chk(scl_en == 1'b1, "R8 released after stop", int'(scl_en), 1);
    chk(!setup_stb && !change_stb && !sample_stb, "R8 strobes quiet",
        int'(setup_stb) + int'(change_stb) + int'(sample_stb), 0);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL R8 watchdog act=%0d exp=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int cdf, g, r, code, m, nb;
    errs = 0; checks = 0;
    rst_n = 1'b0; run = 1'b0; pre_div = 3'd2; gap_steps = '0; edge_comp = '0;
    lead_wr = 1'b0; lead_din = '0; stretch = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(scl_en == 1'b1, "R9 scl released in reset", int'(scl_en), 1);
    chk(!tick && !setup_stb && !change_stb && !sample_stb, "R9 quiet in reset",
        int'(tick) + int'(setup_stb) + int'(change_stb) + int'(sample_stb), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(scl_en == 1'b1, "R9 scl released after reset", int'(scl_en), 1);

    // R3 reset default code gives 6 ticks; R2 minimum period of 20
    run_case(2, 0, 0, 6, 0, 2);
    // R3 code 15 gives 17 ticks; odd period; R7 stretch of 2 ticks
    write_lead(15);
    run_case(3, 1, 1, 17, 2, 2);
    // R3 code 0 gives 2 ticks; largest period
    write_lead(0);
    run_case(2, 63, 63, 2, 1, 1);
    // R3 code 4 again gives 6 ticks
    write_lead(4);
    run_case(4, 2, 5, 6, 0, 1);

    void'($urandom(32'd1234));
    for (int i = 0; i < 10; i++) begin
      cdf  = 2 + int'($urandom_range(2));
      g    = int'($urandom_range(15));
      r    = int'($urandom_range(63));
      code = int'($urandom_range(15));
      m    = int'($urandom_range(3));
      nb   = 1 + int'($urandom_range(2));
      write_lead(code);
      run_case(cdf, g, r, code + 2, m, nb);
    end

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule